// File: doc/BRIEF.md
# Row-to-Serial Transfer Engine

This block is the transfer engine of a dual-port video memory. A random-access array holds rows of words, and a serial register holds one row's worth of words behind a serial port that steps one word at a time. A transfer cycle copies data between one array row and the serial register, in either direction. It can move the whole row or only one half of it. The array is split into two sides by the top row-address bit. Each side owns its own serial bank, so no transfer can carry a word from one side to the other.

A transfer is requested with active-low strobes, sampled on the system clock. On the falling edge of the row strobe, the engine latches the row, the direction (write enable) and the split/full choice. On the following falling edge of the column strobe, it latches the starting serial pointer and, for a split transfer, the half to use. It then copies one word per clock, with `busy` high. A full read transfer turns the serial port to output and a full write transfer turns it to input. Split transfers keep the port direction unchanged. Between transfers, each `serStep` pulse moves the serial pointer by one word. In output mode the pulse reads the word at the pointer. In input mode it writes `serIn` there.

Top module: `row_sam_xfer`

## Requirements
- R1: A transfer starts only if `xferN` is low on the clock where a falling edge of `rowStrobeN` is seen. If `xferN` is high at that edge, `busy` stays low and neither the serial data nor the port direction changes, even when `colStrobeN` falls later.
- R2: If `colStrobeN` is already low at the row-strobe falling edge, no transfer starts and `busy` stays low.
- R3: The direction is decoded at the row-strobe edge: `wrEnN` high selects array-to-serial (read), and `wrEnN` low selects serial-to-array (write). `splitMode` high selects a half-row transfer and low selects a full-row transfer.
- R4: A full read transfer copies all DEPTH words of the addressed row into the serial bank of that row's side. `busy` stays high for exactly DEPTH negedge samples, counted from the first sample after `colStrobeN` is driven low.
- R5: A full write transfer copies all DEPTH words of the side's serial bank into the addressed row. It has the same busy length as R4.
- R6: A split read transfer copies only the half selected by `colAddr[COL_W-1]` (0 = words 0..DEPTH/2-1, 1 = upper words). The other half of the serial bank is left unchanged, and `busy` lasts DEPTH/2 samples.
- R7: A split write transfer writes only the selected half of the addressed row. The other half of the row is left unchanged.
- R8: When a full read transfer completes, `serDir` goes to 1 (output). When a full write transfer completes, `serDir` goes to 0 (input). Split transfers leave `serDir` unchanged.
- R9: The side is `rowAddr[ROW_W-1]`. Each side has its own serial bank. A transfer uses only its own side's bank, and the serial port works on the bank of the side of the last transfer.
- R10: On the column-strobe falling edge, the serial pointer loads `colAddr`. Each idle `serStep` adds one. The pointer wraps modulo DEPTH after a full transfer, and within the selected half (top pointer bit held) after a split transfer.
- R11: With `busy` low, a `serStep` in output mode presents the word at the pointer on `serOut`, and in input mode it stores `serIn` there. `serStep` pulses while `busy` is high are ignored.
- R12: After reset, `busy` is 0, `serDir` is 0 (input), the pointer is 0 with full wrap, and side 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowStrobeN | input | 1 | Row strobe, active low; its falling edge latches the cycle type |
| colStrobeN | input | 1 | Column strobe, active low; its falling edge latches the serial start address |
| xferN | input | 1 | Transfer request, active low at the row-strobe edge |
| wrEnN | input | 1 | Direction select at the row-strobe edge (high = read transfer) |
| splitMode | input | 1 | High = half-row transfer |
| rowAddr | input | ROW_W | Array row; top bit selects the side |
| colAddr | input | COL_W | Serial start address; top bit selects the half in split mode |
| serStep | input | 1 | One serial clock per cycle where it is high |
| serIn | input | DATA_W | Serial write data |
| serOut | output | DATA_W | Word at the serial pointer |
| serDir | output | 1 | Serial port direction, 1 = output |
| busy | output | 1 | High from the row-strobe edge of a transfer until its copy ends |

## Verification
The assertions check properties that hold on every clock. A transfer can only begin from the strobe condition of R1 and R2. Completing a full transfer sets the port direction. A split transfer never changes the direction while it runs. The pointer stays still during a copy and keeps its half bit under split wrap. Whether the right words landed in the right half of the right side's storage, and whether a side's bank kept data that another side's transfer had no right to touch, can only be shown by the bench's scenarios. They do this by writing known patterns, moving them through full and split transfers on both sides, and reading the serial stream back against a behavioural model.

// File: rtl/row_sam_xfer_pkg.sv
package row_sam_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_COL = 2'd1,
    ST_COPY     = 2'd2
  } xferState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic copyEn;  // move one word this cycle
    logic toSam;   // 1: array -> serial bank, 0: serial bank -> array
    logic serWr;   // serial input write at the pointer
  } dpStrobes_t;

endpackage

// File: rtl/row_sam_xfer_ctrl.sv
module row_sam_xfer_ctrl
  import row_sam_xfer_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int DEPTH = 512,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rowStrobeN,
  input  logic             colStrobeN,
  input  logic             xferN,
  input  logic             wrEnN,
  input  logic             splitMode,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic [COL_W-1:0] colAddr,
  input  logic             serStep,
  output dpStrobes_t       strb,
  output logic [ROW_W-1:0] xRow,
  output logic [COL_W-1:0] xIdx,
  output logic             side,
  output logic [COL_W-1:0] ptr,
  output logic             serDir,
  output logic             busy
);

  xferState_t state;
  logic rowPrev, colPrev;
  logic latToSam, latSplit, splitWrap, dirOut;
  logic [ROW_W-1:0] latRow;
  logic [COL_W-1:0] idx, endIdx, nextPtr;
  logic rowFall, colFall, startXfer;

  assign rowFall   = rowPrev & ~rowStrobeN;
  assign colFall   = colPrev & ~colStrobeN;
  assign startXfer = (state == ST_IDLE) && rowFall && !xferN && colStrobeN;

  always_comb begin
    if (splitWrap) nextPtr = {ptr[COL_W-1], ptr[COL_W-2:0] + 1'b1};
    else           nextPtr = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowPrev <= 1'b1;
      colPrev <= 1'b1;
    end else begin
      rowPrev <= rowStrobeN;
      colPrev <= colStrobeN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      latToSam  <= 1'b0;
      latSplit  <= 1'b0;
      latRow    <= '0;
      idx       <= '0;
      endIdx    <= '0;
      side      <= 1'b0;
      ptr       <= '0;
      splitWrap <= 1'b0;
      dirOut    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startXfer) begin
            latToSam <= wrEnN;
            latSplit <= splitMode;
            latRow   <= rowAddr;
            state    <= ST_WAIT_COL;
          end else if (serStep) begin
            ptr <= nextPtr;
          end
        end
        ST_WAIT_COL: begin
          if (rowStrobeN) begin
            state <= ST_IDLE;
          end else if (colFall) begin
            ptr       <= colAddr;
            splitWrap <= latSplit;
            side      <= latRow[ROW_W-1];
            if (latSplit) begin
              idx    <= {colAddr[COL_W-1], {(COL_W-1){1'b0}}};
              endIdx <= {colAddr[COL_W-1], {(COL_W-1){1'b1}}};
            end else begin
              idx    <= '0;
              endIdx <= '1;
            end
            state <= ST_COPY;
          end
        end
        ST_COPY: begin
          if (idx == endIdx) begin
            state <= ST_IDLE;
            if (!latSplit) dirOut <= latToSam;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strb.copyEn = (state == ST_COPY);
  assign strb.toSam  = latToSam;
  assign strb.serWr  = (state == ST_IDLE) && !startXfer && serStep && !dirOut;
  assign xRow   = latRow;
  assign xIdx   = idx;
  assign serDir = dirOut;
  assign busy   = (state != ST_IDLE);

  // R1: leaving idle needs the transfer strobe low at a row-strobe fall
  p_start_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(rowFall && !xferN)) |=> (state == ST_IDLE));

  // R2: column strobe already low at the row edge blocks a transfer
  p_no_start_col_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !colStrobeN) |=> (state == ST_IDLE));

  // R8: completing a full read sets output, a full write sets input
  p_full_read_dir_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COPY && idx == endIdx && !latSplit && latToSam) |=> serDir);
  p_full_write_dir_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COPY && idx == endIdx && !latSplit && !latToSam) |=> !serDir);

  // R8: a split copy never alters the direction
  p_split_dir_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COPY && latSplit) |=> $stable(serDir));

  // R10: split wrap keeps the half bit of the pointer
  p_split_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && serStep && splitWrap && !startXfer)
      |=> (ptr[COL_W-1] == $past(ptr[COL_W-1])));

  // R11: the pointer does not move during a copy
  p_copy_freezes_ptr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COPY && $past(state) == ST_COPY) |-> $stable(ptr));

endmodule

// File: rtl/row_sam_xfer_dp.sv
module row_sam_xfer_dp
  import row_sam_xfer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROWS   = 4,
  parameter int DEPTH  = 512,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [ROW_W-1:0]  xRow,
  input  logic [COL_W-1:0]  xIdx,
  input  logic              side,
  input  logic [COL_W-1:0]  ptr,
  input  logic [DATA_W-1:0] serIn,
  output logic [DATA_W-1:0] serOut
);

  logic [DATA_W-1:0] ramMem [ROWS*DEPTH];
  logic [DATA_W-1:0] copyRd [2];
  logic [DATA_W-1:0] serRd  [2];
  logic [DATA_W-1:0] ramRd;
  logic              copySide;

  assign copySide = xRow[ROW_W-1];
  assign ramRd    = ramMem[{xRow, xIdx}];

  // One serial bank per array side
  for (genvar s = 0; s < 2; s++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.copyEn && strb.toSam && copySide == 1'(s))
        mem[xIdx] <= ramRd;
      else if (strb.serWr && side == 1'(s))
        mem[ptr] <= serIn;
    end
    assign copyRd[s] = mem[xIdx];
    assign serRd[s]  = mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (strb.copyEn && !strb.toSam)
      ramMem[{xRow, xIdx}] <= copyRd[copySide];
  end

  assign serOut = serRd[side];

  // R11: serial writes never collide with a copy
  p_copy_serial_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.copyEn |-> !strb.serWr);

endmodule

// File: rtl/row_sam_xfer.sv
module row_sam_xfer
  import row_sam_xfer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROWS   = 4,
  parameter int DEPTH  = 512,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowStrobeN,
  input  logic              colStrobeN,
  input  logic              xferN,
  input  logic              wrEnN,
  input  logic              splitMode,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  input  logic              serStep,
  input  logic [DATA_W-1:0] serIn,
  output logic [DATA_W-1:0] serOut,
  output logic              serDir,
  output logic              busy
);

  dpStrobes_t       strb;
  logic [ROW_W-1:0] xRow;
  logic [COL_W-1:0] xIdx, ptr;
  logic             side;

  row_sam_xfer_ctrl #(.ROWS(ROWS), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .xferN(xferN), .wrEnN(wrEnN), .splitMode(splitMode), .rowAddr(rowAddr),
    .colAddr(colAddr), .serStep(serStep), .strb(strb), .xRow(xRow),
    .xIdx(xIdx), .side(side), .ptr(ptr), .serDir(serDir), .busy(busy)
  );

  row_sam_xfer_dp #(.DATA_W(DATA_W), .ROWS(ROWS), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .xRow(xRow), .xIdx(xIdx),
    .side(side), .ptr(ptr), .serIn(serIn), .serOut(serOut)
  );

endmodule

// File: tb/row_sam_xfer_tb.sv
`timescale 1ns/100ps
module row_sam_xfer_tb;
  localparam int W     = 16;
  localparam int ROWS  = 4;
  localparam int DEPTH = 512;
  localparam int HALF  = DEPTH / 2;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowStrobeN = 1'b1, colStrobeN = 1'b1, xferN = 1'b1, wrEnN = 1'b1;
  logic splitMode = 1'b0, serStep = 1'b0;
  logic [ROW_W-1:0] rowAddr = '0;
  logic [COL_W-1:0] colAddr = '0;
  logic [W-1:0] serIn = '0;
  logic [W-1:0] serOut;
  logic serDir, busy;

  always #2 clk = ~clk;

  row_sam_xfer #(.DATA_W(W), .ROWS(ROWS), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .xferN(xferN), .wrEnN(wrEnN), .splitMode(splitMode), .rowAddr(rowAddr),
    .colAddr(colAddr), .serStep(serStep), .serIn(serIn), .serOut(serOut),
    .serDir(serDir), .busy(busy)
  );

  typedef struct { logic [W-1:0] data; string req; } exp_t;
  exp_t expQ[$];
  int total = 0, bad = 0;
  bit done = 0;

  // behavioural model
  logic [W-1:0] mRam [ROWS][DEPTH];
  logic [W-1:0] mSam [2][DEPTH];
  int mSide = 0, mPtr = 0;
  bit mSplit = 0, mDir = 0;

  function automatic logic [W-1:0] pat(int k, int i);
    return W'((k * 16'h1357) ^ (i * 3 + 1));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares each idle output-mode serial word with the queue
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (rstN && serStep && !busy && serDir) begin
      if (expQ.size() == 0) chk(0, "R11", "unexpected serial read", int'(serOut), 0);
      else begin
        e = expQ.pop_front();
        chk(serOut === e.data, e.req, "serial word", int'(serOut), int'(e.data));
      end
    end
  end

  // driver: serial steps; reads push expectations, writes update the model
  task automatic step(int n, string req, int k);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      serStep <= 1'b1;
      if (mDir) expQ.push_back('{mSam[mSide][mPtr], req});
      else begin
        serIn <= pat(k, i);
        mSam[mSide][mPtr] = pat(k, i);
      end
      if (mSplit) mPtr = (mPtr & HALF) | ((mPtr + 1) % HALF);
      else        mPtr = (mPtr + 1) % DEPTH;
    end
    @(negedge clk);
    serStep <= 1'b0;
  endtask

  task automatic xfer(int row, int col, bit wr, bit split, bit poke, string req);
    int cnt, sd, lo, n;
    @(negedge clk);
    rowAddr <= ROW_W'(row); wrEnN <= !wr; splitMode <= split;
    xferN <= 1'b0; colStrobeN <= 1'b1;
    @(negedge clk); rowStrobeN <= 1'b0;
    @(negedge clk);
    @(negedge clk); xferN <= 1'b1; colAddr <= COL_W'(col); colStrobeN <= 1'b0;
    cnt = 0;
    @(negedge clk);
    while (busy && cnt < DEPTH + 8) begin
      cnt++;
      if (poke && cnt == 2) serStep <= 1'b1;   // R11: ignored while busy
      if (poke && cnt == 4) serStep <= 1'b0;
      @(negedge clk);
    end
    rowStrobeN <= 1'b1; colStrobeN <= 1'b1;
    n = split ? HALF : DEPTH;
    chk(cnt == n, req, "busy length", cnt, n);
    sd = row >> (ROW_W - 1);
    lo = split ? (col & HALF) : 0;
    for (int i = 0; i < n; i++) begin
      if (wr) mRam[row][lo + i] = mSam[sd][lo + i];
      else    mSam[sd][lo + i] = mRam[row][lo + i];
    end
    mSide = sd; mPtr = col; mSplit = split;
    if (!split) mDir = !wr;
    chk(serDir == mDir, "R8", "port direction", int'(serDir), int'(mDir));
  endtask

  task automatic noXfer(bit xHigh, bit cLow, string req);
    @(negedge clk); xferN <= xHigh; colStrobeN <= !cLow;
    @(negedge clk); rowStrobeN <= 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 1 && !cLow) colStrobeN <= 1'b0;
      chk(busy == 1'b0, req, "busy after row fall", int'(busy), 0);
    end
    rowStrobeN <= 1'b1; colStrobeN <= 1'b1; xferN <= 1'b1;
    @(negedge clk);
    chk(serDir == mDir, req, "direction untouched", int'(serDir), int'(mDir));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN <= 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R12", "busy after reset", int'(busy), 0);
    chk(serDir == 1'b0, "R12", "direction after reset", int'(serDir), 0);

    step(DEPTH, "R11", 1);               // bank0 <= P1 (pointer starts at 0, R12)
    xfer(0, 0, 1, 0, 0, "R5");           // row0 <= P1
    step(DEPTH, "R11", 2);
    xfer(1, 0, 1, 0, 0, "R5");           // row1 <= P2
    xfer(0, 5, 0, 0, 0, "R4");           // bank0 <= row0, output mode
    step(DEPTH + 3, "R10", 0);           // full wrap from 5

    noXfer(1'b1, 1'b0, "R1");
    step(4, "R1", 0);
    noXfer(1'b0, 1'b1, "R2");
    step(4, "R2", 0);

    xfer(2, 0, 1, 0, 0, "R5");           // side 1, input mode
    step(DEPTH, "R11", 3);
    xfer(2, 0, 1, 0, 0, "R5");           // row2 <= P3
    step(DEPTH, "R11", 4);               // bank1 <= P4
    xfer(3, 0, 1, 0, 0, "R9");           // row3 from bank1 only
    xfer(1, 0, 0, 0, 0, "R3");           // bank0 <= P2
    step(8, "R3", 0);
    xfer(3, 0, 0, 0, 0, "R9");
    step(DEPTH, "R9", 0);                // row3 must hold P4, not bank0 data

    xfer(0, HALF + 10, 0, 1, 1, "R6");   // upper half of bank0 <= row0 upper
    step(HALF - 6, "R11", 0);            // half wrap, pointer untouched by poke
    xfer(0, 10, 1, 1, 0, "R7");          // row0 lower <= bank0 lower
    xfer(0, 0, 0, 0, 0, "R7");
    step(DEPTH, "R7", 0);                // row0 = {P2 lower, P1 upper}

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R11", "pending expected words", expQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule